// File: doc/BRIEF.md
# Processor Halt Status Detector

This block watches an 8-bit processor status bus that is sampled once per processor clock, and it raises a halt indication when the sampled stream carries the halt signature. The signature starts with a marker value of 0xB in the low nibble of one byte. A run of all-ones status values follows the marker. The block counts that run in two ways: as whole 0xFF bytes, and as single 0xF nibbles. It declares halt when either count reaches its threshold. The run counters are also brought out to ports so that they can be watched for debug.

Each byte is treated as two nibbles in time order, the high nibble first and then the low nibble. A byte that is not 0xFF ends the byte run. A nibble that is not 0xF ends the nibble run. Both counters stop at their thresholds, so they never wrap during a long halt. Once the halt flag is set it stays set while the high nibble of each sampled byte is 0xF. It drops on the first byte whose high nibble is anything else.

Top module: `halt_status_detect`

## Requirements
- R1: A synchronous active-high reset clears haltFlag, byteRun and nibRun on the next clock edge. All three are 0 in the cycle after reset.
- R2: Each sampled byte equal to 0xFF adds one to byteRun. The count stops at BYTE_LIMIT (default 5) and never goes above it.
- R3: Any sampled byte other than 0xFF sets byteRun to 0 on the same edge.
- R4: nibRun counts consecutive 0xF nibbles, with bits [7:4] of a byte taken before bits [3:0]. A 0xFF byte adds 2, stopping at NIB_LIMIT (default 9). A byte whose low nibble is 0xF and whose high nibble is not 0xF sets the count to 1. Every other byte sets it to 0.
- R5: A byte whose bits [3:0] equal 0xB arms detection, whatever its bits [7:4] hold. Detection stays armed only through an unbroken series of 0xFF bytes that follows the marker. Any other byte disarms it, unless that byte is itself a marker.
- R6: haltFlag is set on the edge at which a byte is sampled while detection is armed, if that byte brings byteRun to BYTE_LIMIT or nibRun to NIB_LIMIT.
- R7: An all-ones run of any length that is not preceded by the marker never sets haltFlag.
- R8: While haltFlag is set, it stays set for every sampled byte whose bits [7:4] are 0xF, whatever its low nibble holds. It clears on the edge that samples the first byte whose bits [7:4] are not 0xF.
- R9: After the marker byte, haltFlag reads 1 in the cycle that follows the edge sampling the fifth consecutive 0xFF byte. It reads 0 after the first four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| statusBus | input | 8 | Status byte sampled on every rising edge |
| haltFlag | output | 1 | Halt detected |
| byteRun | output | $clog2(BYTE_LIMIT+1) | Current count of consecutive 0xFF bytes |
| nibRun | output | $clog2(NIB_LIMIT+1) | Current count of consecutive 0xF nibbles |

## Verification
A fault in the hidden armed state shows up only at haltFlag. It appears either as a halt with no marker before it, or as a missing halt after a run that was broken and then started again. The bench therefore drives runs with no marker, broken runs and clean runs, and compares haltFlag on every cycle. A counter that is off by one or that wraps appears at byteRun or nibRun one cycle after the byte that causes it. It also moves the rising edge of haltFlag one cycle early or late against the fifth 0xFF byte. A wrong clear condition shows as haltFlag staying high past the first byte whose high nibble is not 0xF.

// File: rtl/halt_detect_pkg.sv
package halt_detect_pkg;

  localparam int NIB_W = 4;
  localparam int BUS_W = 2 * NIB_W;

  typedef struct packed {
    logic byteInc;
    logic byteClr;
    logic nibAdd2;
    logic nibSet1;
    logic nibClr;
    logic armSet;
    logic armKeep;
  } runStrobes_t;

endpackage

// File: rtl/halt_run_datapath.sv
module halt_run_datapath
  import halt_detect_pkg::*;
#(
  parameter int NIB_LIMIT  = 9,
  parameter int BYTE_LIMIT = 5,
  parameter int NIB_CW     = $clog2(NIB_LIMIT + 1),
  parameter int BYTE_CW    = $clog2(BYTE_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  runStrobes_t        strobes,
  output logic [BYTE_CW-1:0] byteCnt,
  output logic [NIB_CW-1:0]  nibCnt,
  output logic               armed,
  output logic               byteHit,
  output logic               nibHit
);

  localparam logic [BYTE_CW-1:0] BYTE_MAX  = BYTE_CW'(BYTE_LIMIT);
  localparam logic [NIB_CW-1:0]  NIB_MAX   = NIB_CW'(NIB_LIMIT);
  localparam logic [NIB_CW-1:0]  NIB_EDGE  = NIB_CW'(NIB_LIMIT - 2);

  logic [BYTE_CW-1:0] byteNext;
  logic [NIB_CW-1:0]  nibNext;
  logic               armNext;

  always_comb begin
    byteNext = byteCnt;
    if (strobes.byteClr) begin
      byteNext = '0;
    end else if (strobes.byteInc) begin
      if (byteCnt >= BYTE_MAX) byteNext = BYTE_MAX;
      else                     byteNext = byteCnt + 1'b1;
    end
  end

  always_comb begin
    nibNext = nibCnt;
    if (strobes.nibClr) begin
      nibNext = '0;
    end else if (strobes.nibSet1) begin
      nibNext = NIB_CW'(1);
    end else if (strobes.nibAdd2) begin
      if (nibCnt >= NIB_EDGE) nibNext = NIB_MAX;
      else                    nibNext = nibCnt + NIB_CW'(2);
    end
  end

  always_comb begin
    if (strobes.armSet)       armNext = 1'b1;
    else if (strobes.armKeep) armNext = armed;
    else                      armNext = 1'b0;
  end

  assign byteHit = (byteNext == BYTE_MAX);
  assign nibHit  = (nibNext == NIB_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt <= '0;
      nibCnt  <= '0;
      armed   <= 1'b0;
    end else begin
      byteCnt <= byteNext;
      nibCnt  <= nibNext;
      armed   <= armNext;
    end
  end

endmodule

// File: rtl/halt_run_control.sv
module halt_run_control
  import halt_detect_pkg::*;
#(
  parameter logic [NIB_W-1:0] MARKER = 4'hB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] statusBus,
  input  logic             armed,
  input  logic             byteHit,
  input  logic             nibHit,
  output runStrobes_t      strobes,
  output logic             haltFlag
);

  localparam logic [NIB_W-1:0] NIB_ONES = '1;

  logic [NIB_W-1:0] hiNib;
  logic [NIB_W-1:0] loNib;
  logic             hiOnes;
  logic             loOnes;
  logic             byteOnes;
  logic             haltNext;

  assign hiNib    = statusBus[BUS_W-1:NIB_W];
  assign loNib    = statusBus[NIB_W-1:0];
  assign hiOnes   = (hiNib == NIB_ONES);
  assign loOnes   = (loNib == NIB_ONES);
  assign byteOnes = hiOnes && loOnes;

  always_comb begin
    strobes         = '0;
    strobes.byteInc = byteOnes;
    strobes.byteClr = !byteOnes;
    strobes.nibAdd2 = byteOnes;
    strobes.nibSet1 = loOnes && !hiOnes;
    strobes.nibClr  = !loOnes;
    strobes.armSet  = (loNib == MARKER);
    strobes.armKeep = byteOnes;
  end

  always_comb begin
    if (haltFlag) haltNext = hiOnes;
    else          haltNext = armed && (byteHit || nibHit);
  end

  always_ff @(posedge clk) begin
    if (rst) haltFlag <= 1'b0;
    else     haltFlag <= haltNext;
  end

endmodule

// File: rtl/halt_status_detect.sv
module halt_status_detect
  import halt_detect_pkg::*;
#(
  parameter int NIB_LIMIT  = 9,
  parameter int BYTE_LIMIT = 5,
  parameter int NIB_CW     = $clog2(NIB_LIMIT + 1),
  parameter int BYTE_CW    = $clog2(BYTE_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         statusBus,
  output logic               haltFlag,
  output logic [BYTE_CW-1:0] byteRun,
  output logic [NIB_CW-1:0]  nibRun
);

  runStrobes_t strobes;
  logic        armed;
  logic        byteHit;
  logic        nibHit;

  halt_run_control #(
    .MARKER(4'hB)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .statusBus(statusBus),
    .armed    (armed),
    .byteHit  (byteHit),
    .nibHit   (nibHit),
    .strobes  (strobes),
    .haltFlag (haltFlag)
  );

  halt_run_datapath #(
    .NIB_LIMIT (NIB_LIMIT),
    .BYTE_LIMIT(BYTE_LIMIT),
    .NIB_CW    (NIB_CW),
    .BYTE_CW   (BYTE_CW)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .byteCnt(byteRun),
    .nibCnt (nibRun),
    .armed  (armed),
    .byteHit(byteHit),
    .nibHit (nibHit)
  );

endmodule

// File: rtl/halt_status_checker.sv
module halt_status_checker #(
  parameter int NIB_LIMIT  = 9,
  parameter int BYTE_LIMIT = 5,
  parameter int NIB_CW     = 4,
  parameter int BYTE_CW    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         statusBus,
  input logic               haltFlag,
  input logic [BYTE_CW-1:0] byteRun,
  input logic [NIB_CW-1:0]  nibRun
);

  localparam logic [BYTE_CW-1:0] BMAX = BYTE_CW'(BYTE_LIMIT);
  localparam logic [NIB_CW-1:0]  NMAX = NIB_CW'(NIB_LIMIT);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!haltFlag && byteRun == '0 && nibRun == '0));

  assert_byte_sat_R2: assert property (@(posedge clk) disable iff (rst)
    byteRun <= BMAX);

  assert_byte_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (statusBus == 8'hFF && byteRun < BMAX) |=> byteRun == $past(byteRun) + 1'b1);

  assert_byte_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (statusBus != 8'hFF) |=> byteRun == '0);

  assert_nib_sat_R4: assert property (@(posedge clk) disable iff (rst)
    nibRun <= NMAX);

  assert_nib_break_R4: assert property (@(posedge clk) disable iff (rst)
    (statusBus[3:0] != 4'hF) |=> nibRun == '0);

  assert_halt_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(haltFlag) |-> (byteRun == BMAX || nibRun == NMAX));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (haltFlag && statusBus[7:4] == 4'hF) |=> haltFlag);

  assert_halt_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (haltFlag && statusBus[7:4] != 4'hF) |=> !haltFlag);

endmodule

bind halt_status_detect halt_status_checker #(
  .NIB_LIMIT (NIB_LIMIT),
  .BYTE_LIMIT(BYTE_LIMIT),
  .NIB_CW    (NIB_CW),
  .BYTE_CW   (BYTE_CW)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .statusBus(statusBus),
  .haltFlag (haltFlag),
  .byteRun  (byteRun),
  .nibRun   (nibRun)
);

// File: tb/sim_halt_status_detect.sv
`timescale 1ns/1ps
module sim_halt_status_detect;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] statusBus = 8'h00;
  logic       haltFlag;
  logic [2:0] byteRun;
  logic [3:0] nibRun;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  int mByte = 0;
  int mNib  = 0;
  int mArm  = 0;
  int mHalt = 0;

  always #2 clk = ~clk;

  halt_status_detect u0 (
    .clk      (clk),
    .rst      (rst),
    .statusBus(statusBus),
    .haltFlag (haltFlag),
    .byteRun  (byteRun),
    .nibRun   (nibRun)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=%0d cycles expected<5000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic modelUpdate(input logic [7:0] b, input logic r);
    int nb, nn, na, nh;
    if (r) begin
      mByte = 0; mNib = 0; mArm = 0; mHalt = 0;
      return;
    end
    nb = (b == 8'hFF) ? ((mByte + 1 > 5) ? 5 : mByte + 1) : 0;
    if (b == 8'hFF)           nn = (mNib + 2 > 9) ? 9 : mNib + 2;
    else if (b[3:0] == 4'hF)  nn = 1;
    else                      nn = 0;
    if (mHalt != 0) nh = (b[7:4] == 4'hF) ? 1 : 0;
    else            nh = (mArm != 0 && (nb >= 5 || nn >= 9)) ? 1 : 0;
    if (b[3:0] == 4'hB)       na = 1;
    else if (b == 8'hFF)      na = mArm;
    else                      na = 0;
    mByte = nb; mNib = nn; mArm = na; mHalt = nh;
  endtask

  task automatic compare(input string tag);
    total++;
    if (haltFlag !== mHalt[0] || byteRun !== mByte[2:0] || nibRun !== mNib[3:0]) begin
      bad++;
      $display("FAIL %s: actual halt=%0b byte=%0d nib=%0d expected halt=%0d byte=%0d nib=%0d",
               tag, haltFlag, byteRun, nibRun, mHalt, mByte, mNib);
    end
  endtask

  task automatic step(input logic [7:0] b, input string tag);
    statusBus = b;
    @(posedge clk);
    modelUpdate(b, rst);
    #1;
    compare(tag);
  endtask

  task automatic expectHalt(input logic exp, input string tag);
    total++;
    if (haltFlag !== exp) begin
      bad++;
      $display("FAIL %s: actual halt=%0b expected halt=%0b", tag, haltFlag, exp);
    end
  endtask

  initial begin
    rst = 1'b1;
    step(8'h00, "R1 reset");
    step(8'hFF, "R1 reset held");
    rst = 1'b0;
    // no marker: long run must not halt, counters saturate
    for (int i = 0; i < 7; i++) step(8'hFF, "R7 R2 R4 unmarked run");
    expectHalt(1'b0, "R7 no halt without marker");
    step(8'h12, "R3 non-ones byte clears");
    // nibble patterns
    step(8'h0F, "R4 low nibble only");
    step(8'hFF, "R4 add two after one");
    step(8'hF0, "R4 low zero breaks");
    step(8'hF7, "R4 high ones low break");
    // marked run reaches halt on fifth byte
    step(8'h3B, "R5 marker");
    for (int i = 0; i < 4; i++) step(8'hFF, "R9 four bytes");
    expectHalt(1'b0, "R9 not after four");
    step(8'hFF, "R6 R9 fifth byte");
    expectHalt(1'b1, "R9 halt after fifth");
    step(8'hFF, "R8 hold ones");
    step(8'hF3, "R8 hold high nibble ones");
    expectHalt(1'b1, "R8 still halted");
    step(8'h2F, "R8 clear on non-ones high");
    expectHalt(1'b0, "R8 cleared");
    // broken run disarms
    step(8'hAB, "R5 marker again");
    step(8'hFF, "R5 run");
    step(8'hFF, "R5 run");
    step(8'h7F, "R5 break disarms");
    for (int i = 0; i < 6; i++) step(8'hFF, "R5 R7 run after break");
    expectHalt(1'b0, "R5 no halt after break");
    // marker byte with all-ones high nibble, then reset mid halt
    step(8'hFB, "R5 marker high ones");
    for (int i = 0; i < 5; i++) step(8'hFF, "R6 run");
    expectHalt(1'b1, "R6 halt");
    rst = 1'b1;
    step(8'hFF, "R1 reset during halt");
    rst = 1'b0;
    expectHalt(1'b0, "R1 halt cleared");
    step(8'h5B, "R5 marker");
    step(8'hFF, "R2 run");
    step(8'h00, "R3 clear");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule